// File: doc/BRIEF.md
# Edge-Cleared Watchdog Timer

This block watches a software "kick" line that a processor must toggle at regular intervals. Every change of level, whether rising or falling, restarts a quiet-time window. If the window runs out with no change, the block raises a single-cycle timeout strobe toward the reset generator. That generator then asserts system reset and stretches it. While the system reset is asserted, the window counter is held at zero. It starts counting again on the first clock edge after release.

The kick line is asynchronous to the block clock. It passes through a multi-stage synchronizer, and a registered copy of the synchronized level is compared with the live level to detect a change in either direction. The timeout length is given in clock cycles, so the nominal 1.6 s window (allowed range 1.12 s to 2.24 s) becomes a cycle count at the chosen clock rate. After a timeout the counter stays at zero and ignores kicks until the next reset.

If the kick line is left stuck high or low, the block and the reset generator produce a steady train of resets. Their period is the timeout length plus the reset hold time.

Top module: `wdt_edge_guard`

## Requirements
- R1: While `sys_rst_i` is sampled high at a clock edge, `expire_o` is low after that edge and the window counter is zero.
- R2: After reset is released with no kick transition, `expire_o` goes high after the TIMEOUT_CYC-th clock edge at which `sys_rst_i` is sampled low.
- R3: A kick transition in either direction (0 to 1 or 1 to 0) restarts the window. The transition is driven before clock edge n and, with SYNC_STAGES = 2, clears the counter at edge n+2. The strobe then follows after edge n+2+TIMEOUT_CYC, unless a further transition arrives.
- R4: A kick pulse of one clock period, high or low, is seen as two transitions, and both restart the window.
- R5: `expire_o` is high for exactly one clock cycle per timeout.
- R6: After a timeout, `expire_o` stays low and kick transitions have no effect until `sys_rst_i` is asserted again.
- R7: Kick transitions that settle at least SYNC_STAGES+1 cycles before reset release have no effect. The window still runs its full TIMEOUT_CYC cycles from release.
- R8: With the kick line stuck at either level, and reset held for REC cycles after each strobe, strobes recur every TIMEOUT_CYC + REC cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| sys_rst_i | input | 1 | Current system reset state from the reset generator, active high, synchronous to clk_i |
| kick_i | input | 1 | Asynchronous watchdog service line toggled by the processor |
| expire_o | output | 1 | One-cycle timeout strobe to the reset generator |

## Verification
The assertions assume that `sys_rst_i` is synchronous to `clk_i` and is asserted from the first clock edge for at least SYNC_STAGES+1 cycles. The synchronizer and edge-detector flops carry no reset, so they need that time to fill with known values. The bench meets this by starting in reset for several cycles. It changes `kick_i` and `sys_rst_i` only on falling clock edges. Between its own reset pulses it lets the kick line rest for at least SYNC_STAGES+1 cycles before each release. The random phase draws kick gaps that both fall short of and exceed the window, so clears and timeouts alternate.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

   // Counter phase: counting a window, or spent until the next reset
   typedef enum logic {
      WDG_ARMED = 1'b0,
      WDG_SPENT = 1'b1
   } wdg_phase_e;

   // Bits needed to hold values 0 .. limit-1
   function automatic int unsigned cnt_bits(input int unsigned limit);
      return (limit < 2) ? 1 : $clog2(limit);
   endfunction

endpackage

// File: rtl/wdg_sync_chain.sv
module wdg_sync_chain #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic async_i,
   output logic sync_o
);
   logic [STAGES-1:0] stage_q;

   generate
      if (STAGES == 2) begin : g_two
         always_ff @(posedge clk_i) begin
            stage_q <= {stage_q[0], async_i};
         end
      end else begin : g_deep
         always_ff @(posedge clk_i) begin
            stage_q <= {stage_q[STAGES-2:0], async_i};
         end
      end
   endgenerate

   assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/wdg_toggle_detect.sv
module wdg_toggle_detect (
   input  logic clk_i,
   input  logic level_i,
   output logic toggle_o
);
   logic last_q;

   // Tracks the level continuously, also during reset, so release sees no stale edge
   always_ff @(posedge clk_i) begin
      last_q <= level_i;
   end

   assign toggle_o = level_i ^ last_q;
endmodule

// File: rtl/wdg_quiet_counter.sv
module wdg_quiet_counter #(
   parameter int unsigned LIMIT = 16,
   parameter int unsigned W     = 4
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic         clear_i,
   output logic [W-1:0] count_o,
   output logic         strobe_o
);
   import wdg_pkg::*;

   localparam logic [W-1:0] LAST = W'(LIMIT - 1);

   wdg_phase_e   phase_q;
   logic [W-1:0] cnt_q;
   logic         strobe_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cnt_q    <= '0;
         phase_q  <= WDG_ARMED;
         strobe_q <= 1'b0;
      end else begin
         strobe_q <= 1'b0;
         case (phase_q)
            WDG_ARMED: begin
               if (clear_i) begin
                  cnt_q <= '0;
               end else if (cnt_q == LAST) begin
                  cnt_q    <= '0;
                  strobe_q <= 1'b1;
                  phase_q  <= WDG_SPENT;
               end else begin
                  cnt_q <= cnt_q + W'(1);
               end
            end
            default: begin
               cnt_q <= '0;
            end
         endcase
      end
   end

   assign count_o  = cnt_q;
   assign strobe_o = strobe_q;
endmodule

// File: rtl/wdt_edge_guard.sv
module wdt_edge_guard #(
   parameter int unsigned TIMEOUT_CYC = 1_600_000,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic sys_rst_i,
   input  logic kick_i,
   output logic expire_o
);
   localparam int unsigned CNT_W = wdg_pkg::cnt_bits(TIMEOUT_CYC);

   generate
      if (TIMEOUT_CYC < 2) begin : g_bad_timeout
         $error("TIMEOUT_CYC must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic             kick_sync;
   logic             kick_toggle;
   logic [CNT_W-1:0] count_q;

   wdg_sync_chain #(.STAGES(SYNC_STAGES)) sync_i (
      .clk_i   (clk_i),
      .async_i (kick_i),
      .sync_o  (kick_sync)
   );

   wdg_toggle_detect edge_i (
      .clk_i    (clk_i),
      .level_i  (kick_sync),
      .toggle_o (kick_toggle)
   );

   wdg_quiet_counter #(.LIMIT(TIMEOUT_CYC), .W(CNT_W)) cnt_i (
      .clk_i    (clk_i),
      .rst_i    (sys_rst_i),
      .clear_i  (kick_toggle),
      .count_o  (count_q),
      .strobe_o (expire_o)
   );
endmodule

// File: rtl/wdg_edge_guard_chk.sv
module wdg_edge_guard_chk #(
   parameter int unsigned LIMIT = 16,
   parameter int unsigned W     = 4
) (
   input logic         clk_i,
   input logic         sys_rst_i,
   input logic         expire_o,
   input logic [W-1:0] count_q,
   input logic         kick_toggle
);
   // R1
   rst_quiet_chk: assert property (@(posedge clk_i) sys_rst_i |=> !expire_o);

   // R1
   rst_zero_chk: assert property (@(posedge clk_i) sys_rst_i |=> (count_q == '0));

   // R5
   single_pulse_chk: assert property (@(posedge clk_i) disable iff (sys_rst_i)
      expire_o |=> !expire_o);

   // R3
   toggle_clear_chk: assert property (@(posedge clk_i) disable iff (sys_rst_i)
      kick_toggle |=> (count_q == '0));

   // R2
   expiry_at_limit_chk: assert property (@(posedge clk_i) disable iff (sys_rst_i)
      $rose(expire_o) |-> ($past(count_q) == W'(LIMIT - 1)));

   // R2
   count_range_chk: assert property (@(posedge clk_i) disable iff (sys_rst_i)
      (32'(count_q) < LIMIT));
endmodule

bind wdt_edge_guard wdg_edge_guard_chk #(.LIMIT(TIMEOUT_CYC), .W(CNT_W)) chk_i (
   .clk_i       (clk_i),
   .sys_rst_i   (sys_rst_i),
   .expire_o    (expire_o),
   .count_q     (count_q),
   .kick_toggle (kick_toggle)
);

// File: tb/wdt_edge_guard_tb_top.sv
module wdt_edge_guard_tb_top;
   localparam int T   = 20;
   localparam int REC = 7;
   localparam int MAX_CYC = 200000;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic kick = 1'b0;
   logic expire;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;

   // reference model state
   bit m_s1 = 0, m_s2 = 0, m_prev = 0;
   int m_quiet = 0;
   bit m_spent = 0;
   bit m_exp = 0;

   always #10 clk = ~clk;

   wdt_edge_guard #(.TIMEOUT_CYC(T), .SYNC_STAGES(2)) dut_i (
      .clk_i     (clk),
      .sys_rst_i (rst),
      .kick_i    (kick),
      .expire_o  (expire)
   );

   // Quiet-time model: a level change shows up two edges after it is driven
   function automatic void model_edge(input bit r, input bit k);
      bit moved;
      moved  = (m_s2 != m_prev);
      m_prev = m_s2;
      m_s2   = m_s1;
      m_s1   = k;
      m_exp  = 1'b0;
      if (r) begin
         m_quiet = 0;
         m_spent = 1'b0;
      end else if (!m_spent) begin
         if (moved) m_quiet = 0;
         else if (m_quiet == T - 1) begin
            m_exp   = 1'b1;
            m_spent = 1'b1;
            m_quiet = 0;
         end else m_quiet++;
      end
   endfunction

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s cycle %0d: expire_o=%b expected %b", req, cyc, act, exp);
      end
   endtask

   // one clock: drive at falling edge, compare at the next falling edge
   task automatic step(input bit r, input bit k, input string req);
      rst  = r;
      kick = k;
      @(posedge clk);
      model_edge(r, k);
      @(negedge clk);
      cyc++;
      check(req, expire, m_exp);
   endtask

   task automatic hold(input int n, input bit r, input bit k, input string req);
      for (int i = 0; i < n; i++) step(r, k, req);
   endtask

   task automatic supervise(input bit level, input int pulses);
      int rec_left = REC;
      int last = -1;
      int seen = 0;
      for (int i = 0; i < pulses * (T + REC) + 2 * (T + REC) && seen < pulses; i++) begin
         step(rec_left > 0, level, "R8");
         if (rec_left > 0) rec_left--;
         if (expire) begin
            if (last >= 0) begin
               checks++;
               if (cyc - last != T + REC) begin
                  errors++;
                  $display("FAIL R8 level %0b: period %0d expected %0d", level, cyc - last, T + REC);
               end
            end
            last = cyc;
            seen++;
            rec_left = REC;
         end
      end
      checks++;
      if (seen != pulses) begin
         errors++;
         $display("FAIL R8 level %0b: %0d strobes expected %0d", level, seen, pulses);
      end
   endtask

   initial begin
      void'($urandom(32'h5eed_0c4a));
      @(negedge clk);
      // R1: reset state
      hold(6, 1, 0, "R1");
      // R2: stuck low, single strobe T edges after release; R5 pulse width covered per cycle
      hold(T + 4, 0, 0, "R2");
      // R6: kicks after expiry are ignored
      for (int i = 0; i < 3 * T; i++) step(0, i[2], "R6");
      // R7: toggles while in reset, then rest before release
      hold(2, 1, 1, "R7");
      hold(2, 1, 0, "R7");
      hold(4, 1, 1, "R7");
      hold(T + 3, 0, 1, "R7");
      // R3: regular kicks inside the window, both directions
      hold(5, 1, 0, "R1");
      for (int i = 0; i < 10 * T; i++) step(0, ((i / (T / 2)) % 2) == 1, "R3");
      hold(T + 4, 0, 0, "R3");
      // R4: one-cycle high pulse, then one-cycle low pulse
      hold(5, 1, 0, "R1");
      hold(10, 0, 0, "R4");
      step(0, 1, "R4");
      hold(T - 5, 0, 0, "R4");
      hold(T - 5, 0, 1, "R4");
      step(0, 0, "R4");
      hold(T + 5, 0, 1, "R4");
      // R8: stuck low and stuck high with reset generator behaviour
      hold(5, 1, 0, "R1");
      supervise(1'b0, 4);
      hold(5, 1, 1, "R1");
      supervise(1'b1, 4);
      // random kicks with random gaps and occasional resets
      begin
         bit lvl = 0;
         for (int i = 0; i < 150; i++) begin
            int gap = $urandom_range(1, T + T / 2);
            lvl = ~lvl;
            if ($urandom_range(0, 9) == 0) begin
               hold(2, 1, lvl, "R7");
               hold(3, 1, lvl, "R1");
            end
            hold(gap, 0, lvl, "R3");
         end
      end
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (MAX_CYC) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run exceeded %0d cycles, expected completion", MAX_CYC);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule